// File: doc/BRIEF.md
# Parallel Flash Query and Sector Map Probe

After reset, this block takes control of a byte-wide parallel flash bus and works out what is attached. It first issues both common reset commands, so that a part from either command family returns to array read mode. It then issues the query command at a primary offset and looks for the three-byte query signature. If the signature is missing, it repeats the query command at an alternate offset. When a part answers, the block reads the interface code, the device size code, the extension table pointer and the packed erase-region descriptors. It then expands those descriptors into a table of sector base addresses.

The sector table is held in registers, so every entry is visible at the same time. A registered lookup port maps any bus address to the index of the sector that contains it. The block also reports the pair of unlock addresses that later program and erase sequences need. It flags when the part describes more sectors than the table can hold. If no part answers at either offset, it reports that nothing was detected and leaves the table empty.

Top module: `flash_query_probe`

## Requirements
- R1: The first two bus writes after reset are 0xF0 to address 0, then 0xFF to address 0.
- R2: The query command 0xF8-free byte 0x98 is written at address 0x55. Only if no signature is found there is it written a second time at address 0x555. Every bus write carries 0xF0, 0xFF or 0x98, and there are no further writes.
- R3: Detection requires bytes 'Q' (0x51), 'R' (0x52) and 'Y' (0x59) at addresses 0x10, 0x11 and 0x12. Read data is taken in the cycle after the cycle in which `fl_rd` is high. Any other byte counts as no signature at that offset.
- R4: After detection, the block reads these fields: the extension pointer from 0x15 (low byte) and 0x16, the size code from 0x27, the interface code from 0x28 (low byte) and 0x29, and the region count from 0x2C. Region words are read from 0x2D onward, four bytes each, least significant byte first. `iface_code` shows the interface code.
- R5: In each region word, the sector count is bits 15:0 plus one. The sector size is bits 31:16 times 256 bytes, or 128 bytes when that field is zero.
- R6: Sector bases start at FLASH_BASE and advance by the sector size times RATIO. Expansion stops once the offset reaches 2^size-code times RATIO. Table entries beyond `sect_count` read zero.
- R7: If the region count exceeds one, the block reads the byte at the extension pointer plus 15. When that byte equals 3, the regions are expanded in reverse order.
- R8: If the interface code is 2 and BYTE_MODE is set, the unlock addresses are 0xAAA and 0x555. Otherwise they are 0x555 and 0x2AA.
- R9: When the table holds MAX_SECT entries and a further sector still lies inside the device, `sect_overflow` is set and `sect_count` stays at MAX_SECT.
- R10: Without a signature at either offset, `probe_done` rises with `detected` low, and `sect_count` and every table entry are zero.
- R11: One cycle after `lk_addr` is applied, `lk_index` gives the highest sector whose base does not exceed `lk_addr`. It gives 0 when no sector qualifies.
- R12: `fl_rd` and `fl_wr` are never high together, and both stay low once `probe_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a probe when released |
| fl_addr | output | AW | Flash byte address |
| fl_rd | output | 1 | Read strobe |
| fl_wr | output | 1 | Command write strobe |
| fl_wdata | output | 8 | Command byte |
| fl_rdata | input | 8 | Read data, valid the cycle after the strobe |
| probe_done | output | 1 | Probe finished |
| detected | output | 1 | A query signature was found |
| iface_code | output | 16 | Interface code from the query data |
| unlock1 | output | AW | First unlock address |
| unlock2 | output | AW | Second unlock address |
| sect_count | output | $clog2(MAX_SECT+1) | Number of valid sector entries |
| sect_overflow | output | 1 | More sectors described than fit |
| sect_base_flat | output | MAX_SECT*AW | Sector base table; entry i at bits i*AW +: AW |
| lk_addr | input | AW | Address to look up |
| lk_index | output | $clog2(MAX_SECT) | Sector index holding lk_addr |

## Verification
The probe is exercised against several flash images:
- A part that answers at the primary offset, which shows that a single query write is enough.
- A part that answers only at the alternate offset, which proves the retry.
- A part whose signature is wrong in its last byte, which must end undetected.
- A two-region part whose boot flag is 2, and the same part with flag 3, which separates forward from reversed expansion.
- A part with many 128-byte sectors, which tests the table limit.
- A part whose regions describe more than the size code allows, which tests truncation.

Lookups probe below the first base, exact bases, points between bases and the top of the space.

// File: rtl/fqp_pkg.sv
package fqp_pkg;
  localparam logic [7:0] CMD_RESET_ALT = 8'hF0;
  localparam logic [7:0] CMD_RESET_STD = 8'hFF;
  localparam logic [7:0] CMD_QUERY     = 8'h98;
  localparam logic [11:0] QOFF_PRIMARY = 12'h055;
  localparam logic [11:0] QOFF_ALT     = 12'h555;
  localparam logic [7:0] SIG_ADDR      = 8'h10;
  localparam logic [7:0] REGION_ADDR   = 8'h2D;
  localparam logic [7:0] TOP_BOOT_CODE = 8'h03;

  typedef enum logic [3:0] {
    ST_RST_ALT, ST_RST_STD, ST_QCMD, ST_SIG, ST_HDR,
    ST_REG, ST_FLAG, ST_EXP, ST_FAIL, ST_DONE
  } fqp_state_e;
endpackage

// File: rtl/fqp_seq.sv
module fqp_seq
  import fqp_pkg::*;
#(
  parameter int AW        = 24,
  parameter int MAX_REG   = 4,
  parameter bit BYTE_MODE = 1'b1,
  localparam int RW = $clog2(MAX_REG + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [AW-1:0]        fl_addr,
  output logic                 fl_rd,
  output logic                 fl_wr,
  output logic [7:0]           fl_wdata,
  input  logic [7:0]           fl_rdata,
  output logic                 done,
  output logic                 det,
  output logic [15:0]          iface,
  output logic [AW-1:0]        unl1,
  output logic [AW-1:0]        unl2,
  output logic [7:0]           size_code,
  output logic [RW-1:0]        nreg_eff,
  output logic                 reverse,
  output logic [MAX_REG*32-1:0] reg_words,
  output logic                 exp_start,
  input  logic                 exp_fin
);
  fqp_state_e  st;
  logic [1:0]  ph;
  logic [7:0]  idx;
  logic        alt;
  logic [15:0] ext;
  logic [7:0]  nreg;
  logic [AW-1:0] rd_addr;
  logic [7:0]  sig_char;
  logic [7:0]  reg_bytes;

  assign nreg_eff  = (nreg > 8'(MAX_REG)) ? RW'(MAX_REG) : nreg[RW-1:0];
  assign reg_bytes = 8'(nreg_eff) << 2;

  always_comb begin
    case (idx)
      8'd0:    sig_char = 8'h51;
      8'd1:    sig_char = 8'h52;
      default: sig_char = 8'h59;
    endcase
  end

  always_comb begin
    case (st)
      ST_SIG: rd_addr = AW'(SIG_ADDR + idx);
      ST_HDR: begin
        case (idx)
          8'd0:    rd_addr = AW'(8'h15);
          8'd1:    rd_addr = AW'(8'h16);
          8'd2:    rd_addr = AW'(8'h27);
          8'd3:    rd_addr = AW'(8'h28);
          8'd4:    rd_addr = AW'(8'h29);
          default: rd_addr = AW'(8'h2C);
        endcase
      end
      ST_REG:  rd_addr = AW'(REGION_ADDR) + AW'(idx);
      ST_FLAG: rd_addr = AW'(ext) + AW'(15);
      default: rd_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RST_ALT;
      ph        <= '0;
      idx       <= '0;
      alt       <= 1'b0;
      fl_addr   <= '0;
      fl_rd     <= 1'b0;
      fl_wr     <= 1'b0;
      fl_wdata  <= '0;
      ext       <= '0;
      nreg      <= '0;
      size_code <= '0;
      iface     <= '0;
      reg_words <= '0;
      reverse   <= 1'b0;
      exp_start <= 1'b0;
      done      <= 1'b0;
      det       <= 1'b0;
      unl1      <= '0;
      unl2      <= '0;
    end else begin
      fl_rd     <= 1'b0;
      fl_wr     <= 1'b0;
      exp_start <= 1'b0;
      case (st)
        ST_RST_ALT: begin
          fl_wr    <= 1'b1;
          fl_addr  <= '0;
          fl_wdata <= CMD_RESET_ALT;
          st       <= ST_RST_STD;
        end
        ST_RST_STD: begin
          fl_wr    <= 1'b1;
          fl_addr  <= '0;
          fl_wdata <= CMD_RESET_STD;
          st       <= ST_QCMD;
        end
        ST_QCMD: begin
          fl_wr    <= 1'b1;
          fl_addr  <= alt ? AW'(QOFF_ALT) : AW'(QOFF_PRIMARY);
          fl_wdata <= CMD_QUERY;
          idx      <= '0;
          ph       <= '0;
          st       <= ST_SIG;
        end
        ST_SIG, ST_HDR, ST_REG, ST_FLAG: begin
          if (st == ST_REG && ph == 2'd0 && idx == reg_bytes) begin
            idx <= '0;
            if (nreg > 8'd1) begin
              st <= ST_FLAG;
            end else begin
              st        <= ST_EXP;
              exp_start <= 1'b1;
            end
          end else begin
            case (ph)
              2'd0: begin
                fl_rd   <= 1'b1;
                fl_addr <= rd_addr;
                ph      <= 2'd1;
              end
              2'd1: ph <= 2'd2;
              default: begin
                ph <= 2'd0;
                case (st)
                  ST_SIG: begin
                    if (fl_rdata != sig_char) begin
                      if (!alt) begin
                        alt <= 1'b1;
                        st  <= ST_QCMD;
                      end else begin
                        st <= ST_FAIL;
                      end
                    end else if (idx == 8'd2) begin
                      idx <= '0;
                      st  <= ST_HDR;
                    end else begin
                      idx <= idx + 8'd1;
                    end
                  end
                  ST_HDR: begin
                    case (idx)
                      8'd0:    ext[7:0]    <= fl_rdata;
                      8'd1:    ext[15:8]   <= fl_rdata;
                      8'd2:    size_code   <= fl_rdata;
                      8'd3:    iface[7:0]  <= fl_rdata;
                      8'd4:    iface[15:8] <= fl_rdata;
                      default: nreg        <= fl_rdata;
                    endcase
                    if (idx == 8'd5) begin
                      idx <= '0;
                      st  <= ST_REG;
                    end else begin
                      idx <= idx + 8'd1;
                    end
                  end
                  ST_REG: begin
                    reg_words[{idx, 3'b000} +: 8] <= fl_rdata;
                    idx <= idx + 8'd1;
                  end
                  default: begin
                    reverse   <= (fl_rdata == TOP_BOOT_CODE);
                    st        <= ST_EXP;
                    exp_start <= 1'b1;
                  end
                endcase
              end
            endcase
          end
        end
        ST_EXP: begin
          if (exp_fin) begin
            done <= 1'b1;
            det  <= 1'b1;
            if (BYTE_MODE && iface == 16'h0002) begin
              unl1 <= AW'(12'hAAA);
              unl2 <= AW'(12'h555);
            end else begin
              unl1 <= AW'(12'h555);
              unl2 <= AW'(12'h2AA);
            end
            st <= ST_DONE;
          end
        end
        ST_FAIL: begin
          done <= 1'b1;
          det  <= 1'b0;
          st   <= ST_DONE;
        end
        default: st <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/fqp_expand.sv
module fqp_expand #(
  parameter int          AW         = 24,
  parameter int          MAX_SECT   = 16,
  parameter int          MAX_REG    = 4,
  parameter int          RATIO      = 1,
  parameter logic [31:0] FLASH_BASE = 32'h0,
  localparam int RW  = $clog2(MAX_REG + 1),
  localparam int CW  = $clog2(MAX_SECT + 1),
  localparam int IXW = $clog2(MAX_SECT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [7:0]             size_code,
  input  logic [RW-1:0]          nreg_eff,
  input  logic                   reverse,
  input  logic [MAX_REG*32-1:0]  reg_words,
  output logic                   fin,
  output logic [CW-1:0]          sect_count,
  output logic                   overflow,
  output logic [MAX_SECT*AW-1:0] base_flat
);
  logic          busy;
  logic [RW-1:0] step;
  logic [16:0]   jcnt;
  logic [39:0]   off;
  logic [AW-1:0] tbl [MAX_SECT];

  logic [RW-1:0] ri;
  logic [31:0]   word;
  logic [16:0]   rcnt;
  logic [24:0]   rsz;
  logic [39:0]   stride;
  logic [39:0]   devlim;

  assign ri     = reverse ? (nreg_eff - RW'(1) - step) : step;
  assign word   = reg_words[32*ri +: 32];
  assign rcnt   = {1'b0, word[15:0]} + 17'd1;
  assign rsz    = (word[31:16] == 16'd0) ? 25'd128 : {1'b0, word[31:16], 8'd0};
  assign stride = 40'(rsz) * 40'(RATIO);
  assign devlim = (size_code > 8'd35) ? {40{1'b1}} : (40'(RATIO) << size_code);

  generate
    for (genvar g = 0; g < MAX_SECT; g++) begin : g_flat
      assign base_flat[g*AW +: AW] = tbl[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      step       <= '0;
      jcnt       <= '0;
      off        <= '0;
      fin        <= 1'b0;
      sect_count <= '0;
      overflow   <= 1'b0;
      for (int i = 0; i < MAX_SECT; i++) tbl[i] <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        busy       <= 1'b1;
        step       <= '0;
        jcnt       <= '0;
        off        <= '0;
        sect_count <= '0;
        overflow   <= 1'b0;
        for (int i = 0; i < MAX_SECT; i++) tbl[i] <= '0;
      end else if (busy) begin
        if (step >= nreg_eff || off >= devlim) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else if (sect_count == CW'(MAX_SECT)) begin
          overflow <= 1'b1;
          busy     <= 1'b0;
          fin      <= 1'b1;
        end else begin
          tbl[sect_count[IXW-1:0]] <= AW'(FLASH_BASE) + off[AW-1:0];
          sect_count <= sect_count + CW'(1);
          off        <= off + stride;
          if (jcnt + 17'd1 == rcnt) begin
            jcnt <= '0;
            step <= step + RW'(1);
          end else begin
            jcnt <= jcnt + 17'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fqp_lookup.sv
module fqp_lookup #(
  parameter int AW       = 24,
  parameter int MAX_SECT = 16,
  localparam int CW  = $clog2(MAX_SECT + 1),
  localparam int IXW = $clog2(MAX_SECT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MAX_SECT*AW-1:0] base_flat,
  input  logic [CW-1:0]          count,
  input  logic [AW-1:0]          addr,
  output logic [IXW-1:0]         index
);
  logic [IXW-1:0] hit;

  always_comb begin
    hit = '0;
    for (int i = 0; i < MAX_SECT; i++) begin
      if (CW'(i) < count && base_flat[i*AW +: AW] <= addr) hit = IXW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) index <= '0;
    else     index <= hit;
  end
endmodule

// File: rtl/flash_query_probe.sv
module flash_query_probe #(
  parameter int          AW         = 24,
  parameter int          MAX_SECT   = 16,
  parameter int          MAX_REG    = 4,
  parameter int          RATIO      = 1,
  parameter bit          BYTE_MODE  = 1'b1,
  parameter logic [31:0] FLASH_BASE = 32'h0
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [AW-1:0]                 fl_addr,
  output logic                          fl_rd,
  output logic                          fl_wr,
  output logic [7:0]                    fl_wdata,
  input  logic [7:0]                    fl_rdata,
  output logic                          probe_done,
  output logic                          detected,
  output logic [15:0]                   iface_code,
  output logic [AW-1:0]                 unlock1,
  output logic [AW-1:0]                 unlock2,
  output logic [$clog2(MAX_SECT+1)-1:0] sect_count,
  output logic                          sect_overflow,
  output logic [MAX_SECT*AW-1:0]        sect_base_flat,
  input  logic [AW-1:0]                 lk_addr,
  output logic [$clog2(MAX_SECT)-1:0]   lk_index
);
  localparam int RW = $clog2(MAX_REG + 1);

  logic [7:0]            size_code;
  logic [RW-1:0]         nreg_eff;
  logic                  reverse;
  logic [MAX_REG*32-1:0] reg_words;
  logic                  exp_start;
  logic                  exp_fin;

  fqp_seq #(.AW(AW), .MAX_REG(MAX_REG), .BYTE_MODE(BYTE_MODE)) u_seq (
    .clk(clk), .rst(rst),
    .fl_addr(fl_addr), .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata),
    .done(probe_done), .det(detected), .iface(iface_code),
    .unl1(unlock1), .unl2(unlock2),
    .size_code(size_code), .nreg_eff(nreg_eff), .reverse(reverse),
    .reg_words(reg_words), .exp_start(exp_start), .exp_fin(exp_fin)
  );

  fqp_expand #(.AW(AW), .MAX_SECT(MAX_SECT), .MAX_REG(MAX_REG),
               .RATIO(RATIO), .FLASH_BASE(FLASH_BASE)) u_exp (
    .clk(clk), .rst(rst), .start(exp_start),
    .size_code(size_code), .nreg_eff(nreg_eff), .reverse(reverse),
    .reg_words(reg_words), .fin(exp_fin),
    .sect_count(sect_count), .overflow(sect_overflow),
    .base_flat(sect_base_flat)
  );

  fqp_lookup #(.AW(AW), .MAX_SECT(MAX_SECT)) u_lk (
    .clk(clk), .rst(rst), .base_flat(sect_base_flat), .count(sect_count),
    .addr(lk_addr), .index(lk_index)
  );
endmodule

// File: rtl/fqp_chk.sv
module fqp_chk #(
  parameter int          AW         = 24,
  parameter int          MAX_SECT   = 16,
  parameter logic [31:0] FLASH_BASE = 32'h0,
  localparam int CW  = $clog2(MAX_SECT + 1),
  localparam int IXW = $clog2(MAX_SECT)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   fl_rd,
  input logic                   fl_wr,
  input logic [7:0]             fl_wdata,
  input logic                   probe_done,
  input logic                   detected,
  input logic [AW-1:0]          unlock1,
  input logic [AW-1:0]          unlock2,
  input logic [CW-1:0]          sect_count,
  input logic                   sect_overflow,
  input logic [MAX_SECT*AW-1:0] sect_base_flat,
  input logic [IXW-1:0]         lk_index
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fl_rd && fl_wr)); // R12
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    probe_done |-> (!fl_rd && !fl_wr)); // R12
  AST_WRITE_CMDS: assert property (@(posedge clk) disable iff (rst)
    fl_wr |-> (fl_wdata == 8'hF0 || fl_wdata == 8'hFF || fl_wdata == 8'h98)); // R2
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (probe_done && !detected) |-> (sect_count == '0)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    sect_overflow |-> (sect_count == CW'(MAX_SECT))); // R9
  AST_FIRST_BASE: assert property (@(posedge clk) disable iff (rst)
    (probe_done && sect_count != '0) |-> (sect_base_flat[AW-1:0] == AW'(FLASH_BASE))); // R6
  AST_UNLOCK_PAIR: assert property (@(posedge clk) disable iff (rst)
    (probe_done && detected) |->
      ((unlock1 == AW'(12'h555) && unlock2 == AW'(12'h2AA)) ||
       (unlock1 == AW'(12'hAAA) && unlock2 == AW'(12'h555)))); // R8
  AST_LOOKUP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (probe_done && sect_count != '0) |=> (CW'(lk_index) < sect_count)); // R11
endmodule

bind flash_query_probe fqp_chk #(.AW(AW), .MAX_SECT(MAX_SECT), .FLASH_BASE(FLASH_BASE)) i_fqp_chk (
  .clk(clk), .rst(rst), .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_wdata(fl_wdata),
  .probe_done(probe_done), .detected(detected), .unlock1(unlock1), .unlock2(unlock2),
  .sect_count(sect_count), .sect_overflow(sect_overflow),
  .sect_base_flat(sect_base_flat), .lk_index(lk_index)
);

// File: tb/test_flash_query_probe.sv
module test_flash_query_probe;
  localparam int AW = 24;
  localparam int MS = 16;
  localparam int MR = 4;
  localparam int RATIO = 2;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam int CW = $clog2(MS + 1);
  localparam int IXW = $clog2(MS);

  typedef struct packed {
    logic [11:0] qoff;
    logic        bad;
    logic [7:0]  iface;
    logic [7:0]  code;
    logic [7:0]  nreg;
    logic [31:0] r0;
    logic [31:0] r1;
    logic [7:0]  flag;
  } scen_t;

  localparam int NSC = 6;
  localparam scen_t SC [NSC] = '{
    '{12'h055, 1'b0, 8'd2, 8'h10, 8'd1, 32'h0040_0003, 32'h0,          8'd0}, // primary, 4 sectors
    '{12'h555, 1'b0, 8'd1, 8'h11, 8'd2, 32'h0020_0007, 32'h0100_0000, 8'd2}, // alt, forward
    '{12'h555, 1'b0, 8'd1, 8'h11, 8'd2, 32'h0020_0007, 32'h0100_0000, 8'd3}, // alt, reversed
    '{12'h055, 1'b1, 8'd2, 8'h10, 8'd1, 32'h0040_0003, 32'h0,          8'd0}, // bad signature
    '{12'h055, 1'b0, 8'd2, 8'h10, 8'd1, 32'h0000_0013, 32'h0,          8'd0}, // overflow, 128-byte
    '{12'h055, 1'b0, 8'd0, 8'h0D, 8'd1, 32'h0010_0003, 32'h0,          8'd0}  // truncated by size
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] fl_addr;
  logic fl_rd, fl_wr;
  logic [7:0] fl_wdata;
  logic [7:0] fl_rdata = 8'h00;
  logic probe_done, detected;
  logic [15:0] iface_code;
  logic [AW-1:0] unlock1, unlock2;
  logic [CW-1:0] sect_count;
  logic sect_overflow;
  logic [MS*AW-1:0] sect_base_flat;
  logic [AW-1:0] lk_addr = '0;
  logic [IXW-1:0] lk_index;

  always #4 clk = ~clk;

  flash_query_probe #(.AW(AW), .MAX_SECT(MS), .MAX_REG(MR), .RATIO(RATIO),
                      .BYTE_MODE(1'b1), .FLASH_BASE(BASE)) i_flash_query_probe (
    .clk(clk), .rst(rst), .fl_addr(fl_addr), .fl_rd(fl_rd), .fl_wr(fl_wr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .probe_done(probe_done),
    .detected(detected), .iface_code(iface_code), .unlock1(unlock1),
    .unlock2(unlock2), .sect_count(sect_count), .sect_overflow(sect_overflow),
    .sect_base_flat(sect_base_flat), .lk_addr(lk_addr), .lk_index(lk_index)
  );

  // flash model
  logic [7:0] img [256];
  logic qmode = 1'b0;
  logic [11:0] cfg_qoff = 12'h055;
  int wr_n = 0;
  logic [AW-1:0] wlog_a [8];
  logic [7:0] wlog_d [8];

  always @(posedge clk) begin
    if (fl_wr === 1'b1) begin
      if (wr_n < 8) begin
        wlog_a[wr_n] = fl_addr;
        wlog_d[wr_n] = fl_wdata;
      end
      wr_n = wr_n + 1;
      if (fl_wdata == 8'h98 && fl_addr == AW'(cfg_qoff)) qmode <= 1'b1;
      else if (fl_wdata == 8'hF0 || fl_wdata == 8'hFF) qmode <= 1'b0;
    end
    if (fl_rd === 1'b1)
      fl_rdata <= (qmode && fl_addr < AW'(256)) ? img[fl_addr[7:0]] : 8'hEE;
  end

  int total = 0;
  int failed = 0;
  int cyc = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  // expected model
  logic [AW-1:0] exp_b [MS];
  int exp_n;
  bit exp_o;

  task automatic compute_exp(input scen_t s);
    longint off, dev, sz, cnt_r;
    int n, ri;
    bit rev, stop;
    logic [31:0] w;
    off = 0; exp_n = 0; exp_o = 0; stop = 0;
    for (int i = 0; i < MS; i++) exp_b[i] = '0;
    if (s.bad) return;
    n = int'(s.nreg);
    rev = (n > 1) && (s.flag == 8'd3);
    dev = longint'(RATIO) << s.code;
    for (int k = 0; k < n; k++) begin
      ri = rev ? (n - 1 - k) : k;
      w = (ri == 0) ? s.r0 : s.r1;
      cnt_r = longint'(w[15:0]) + 1;
      sz = (w[31:16] == 16'd0) ? 128 : longint'(w[31:16]) * 256;
      for (longint j = 0; j < cnt_r; j++) begin
        if (!stop) begin
          if (off >= dev) stop = 1;
          else if (exp_n == MS) begin exp_o = 1; stop = 1; end
          else begin
            exp_b[exp_n] = AW'(BASE) + AW'(off);
            exp_n++;
            off += sz * RATIO;
          end
        end
      end
    end
  endtask

  task automatic load_img(input scen_t s);
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
    img[8'h10] = 8'h51; img[8'h11] = 8'h52; img[8'h12] = s.bad ? 8'h5A : 8'h59;
    img[8'h15] = 8'h40; img[8'h16] = 8'h00;
    img[8'h27] = s.code; img[8'h28] = s.iface; img[8'h29] = 8'h00;
    img[8'h2C] = s.nreg;
    for (int b = 0; b < 4; b++) begin
      img[8'h2D + b] = s.r0[8*b +: 8];
      img[8'h31 + b] = s.r1[8*b +: 8];
    end
    img[8'h4F] = s.flag;
    cfg_qoff = s.qoff;
  endtask

  task automatic run_probe(input scen_t s);
    int w;
    load_img(s);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    wr_n = 0;
    rst = 1'b0;
    w = 0;
    while (probe_done !== 1'b1 && w < 4000) begin
      @(negedge clk);
      w++;
    end
    chk("R10 probe finishes", 64'(probe_done), 64'd1);
  endtask

  function automatic logic [IXW-1:0] exp_lookup(input logic [AW-1:0] a);
    logic [IXW-1:0] r = '0;
    for (int i = 0; i < exp_n; i++) if (exp_b[i] <= a) r = IXW'(i);
    return r;
  endfunction

  initial begin
    int bad_tbl, busy_n;
    logic [AW-1:0] probes [6];
    // reset state
    repeat (3) @(negedge clk);
    chk("R12 reset done low", 64'(probe_done), 64'd0);
    chk("R12 reset bus idle", 64'({fl_rd, fl_wr}), 64'd0);
    chk("R10 reset count zero", 64'(sect_count), 64'd0);

    for (int k = 0; k < NSC; k++) begin
      compute_exp(SC[k]);
      run_probe(SC[k]);
      chk("R1 first write", 64'({wlog_a[0], wlog_d[0]}), 64'({AW'(0), 8'hF0}));
      chk("R1 second write", 64'({wlog_a[1], wlog_d[1]}), 64'({AW'(0), 8'hFF}));
      chk("R2 primary query", 64'({wlog_a[2], wlog_d[2]}), 64'({AW'(12'h055), 8'h98}));
      chk("R2 write count", 64'(wr_n), (SC[k].qoff == 12'h055 && !SC[k].bad) ? 64'd3 : 64'd4);
      if (wr_n == 4) chk("R2 alternate query", 64'({wlog_a[3], wlog_d[3]}), 64'({AW'(12'h555), 8'h98}));
      chk("R3 detected", 64'(detected), 64'(!SC[k].bad));
      if (!SC[k].bad) begin
        chk("R4 interface code", 64'(iface_code), 64'(SC[k].iface));
        chk("R8 unlock1", 64'(unlock1), (SC[k].iface == 8'd2) ? 64'h0AAA : 64'h0555);
        chk("R8 unlock2", 64'(unlock2), (SC[k].iface == 8'd2) ? 64'h0555 : 64'h02AA);
      end
      chk("R6 R7 R10 sector count", 64'(sect_count), 64'(exp_n));
      chk("R9 overflow flag", 64'(sect_overflow), 64'(exp_o));
      bad_tbl = 0;
      for (int i = 0; i < MS; i++)
        if (sect_base_flat[i*AW +: AW] !== exp_b[i]) bad_tbl++;
      chk("R5 R6 R7 sector table mismatches", 64'(bad_tbl), 64'd0);
      busy_n = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (fl_rd !== 1'b0 || fl_wr !== 1'b0) busy_n++;
      end
      chk("R12 bus idle after done", 64'(busy_n), 64'd0);
    end

    // lookup, directed on the reversed part and the forward part
    for (int v = 1; v <= 2; v++) begin
      compute_exp(SC[v]);
      run_probe(SC[v]);
      probes[0] = AW'(24'h0F_FFFF);
      probes[1] = AW'(BASE);
      probes[2] = exp_b[1];
      probes[3] = exp_b[1] + AW'(24'h1000);
      probes[4] = exp_b[exp_n-1] - AW'(1);
      probes[5] = AW'(24'hFF_FFFF);
      for (int p = 0; p < 6; p++) begin
        lk_addr = probes[p];
        @(negedge clk);
        @(negedge clk);
        chk("R11 lookup index", 64'(lk_index), 64'(exp_lookup(probes[p])));
      end
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule